// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block keeps the descriptor rings that sit between a host and the frame transmitter and frame receiver of an Ethernet MAC. A single table of descriptors lives in the host's register space. Each entry is a pair of words: a status/control word, then a buffer pointer word. A programmable transmit count splits the table. Entries below the count form the transmit ring. Entries from the count upward form the receive ring. Each ring returns to its first entry when it completes an entry whose wrap flag is set.

On the transmit side, the host fills a descriptor and sets its ready flag. The engine then hands the length, the pointer and the two per-frame options to the transmitter through a request/done handshake. When done arrives, it writes back the completion status, clears ready and moves to the next entry. On the receive side, the engine offers the buffer of the current empty descriptor. When the receiver reports a finished frame, it stores the length and status, clears empty and moves on. A frame that arrives while no empty buffer is offered is dropped and raises the busy interrupt. Completions feed a sticky interrupt source register, which is gated by a mask register onto one interrupt line.

The transmit control runs on states TX_IDLE and TX_XFER. TX_IDLE goes to TX_XFER on "fetch" when transmit is enabled and the current entry is ready. TX_XFER goes back to TX_IDLE on "complete" when done is seen. The receive control runs on states RX_OFF and RX_LIVE. RX_OFF goes to RX_LIVE on "open" when receive is enabled. RX_LIVE goes back to RX_OFF on "close" when it is cleared. While the engine is in RX_OFF, the receive pointer is held at the ring start.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset, the following hold: the mode register (0x000) reads 0, the interrupt source (0x004) reads 0, the interrupt mask (0x008) reads 0, and the transmit count (0x00C) reads NUM_DESC/2. tx_req, rx_buf_valid and irq are all 0.
- R2: A write to the transmit count register stores the written value, clamped to NUM_DESC.
- R3: While mode bit 1 is 1 and the current transmit descriptor has status bit 15 (ready) set, the engine asserts tx_req with the following fields: tx_len from status bits 31:16, tx_ptr from the pointer word, tx_pad from bit 12 and tx_crc from bit 11. All of these are held stable until tx_done.
- R4: When tx_done is sampled during a request, the engine writes back that descriptor's status word. Bits 8:0 take tx_status and bit 15 is cleared; the other bits are kept. tx_req then drops.
- R5: After each completion, the ring pointer advances to the next entry. An entry with status bit 13 (wrap) sends the transmit ring back to entry 0 and the receive ring back to entry tx_count. A ring whose current entry is not ready/empty stalls there.
- R6: A completion whose descriptor has bit 14 set raises interrupt source bits as follows. On transmit, it raises bit 1 if any of tx_status bits 0, 2, 3 or 8 is set, and bit 0 otherwise. On receive, it raises bit 3 if any of rx_status bits 7:0 is set, else bit 6 if bit 8 is set, else bit 2. With bit 14 clear, a completion raises nothing.
- R7: Writing to 0x004 clears the source bits that are 1 in the written data.
- R8: Clearing mode bit 1 returns the transmit pointer to entry 0. Clearing mode bit 0 returns the receive pointer to entry tx_count.
- R9: While mode bit 0 is 1 and the current receive descriptor has bit 15 (empty) set, rx_buf_valid is 1 and rx_ptr carries that entry's pointer word.
- R10: An rx_done while rx_buf_valid is 1 writes the current receive entry as follows: bits 31:16 take rx_len, bits 8:0 take rx_status and bit 15 is cleared. Bits 14:9 are kept.
- R11: An rx_done while receive is live and rx_buf_valid is 0 sets source bit 4 (busy). In that case the descriptor and the receive pointer stay unchanged.
- R12: irq is 1 exactly when some bit set in the interrupt source is also set in the mask.
- R13: Descriptor n has its status word at address 0x400+8n and its pointer word at 0x404+8n. Both are written and read back through the host port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from host_addr) |
| tx_req | output | 1 | Transmit request |
| tx_len | output | 16 | Frame length for the transmitter |
| tx_ptr | output | 32 | Buffer pointer for the transmitter |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Transmitter finished the requested frame |
| tx_status | input | 9 | Transmit completion status |
| rx_buf_valid | output | 1 | An empty receive buffer is offered |
| rx_ptr | output | 32 | Pointer of the offered receive buffer |
| rx_done | input | 1 | Receiver finished a frame |
| rx_len | input | 16 | Received length including CRC |
| rx_status | input | 9 | Receive completion status |
| irq | output | 1 | Interrupt line |

## Verification
Register writes, write-backs and interrupt source bits all take effect on the clock edge that samples the strobe. The bench therefore drives each strobe on a falling edge and reads the result after the next rising edge. tx_req rises one edge after both the enable and the ready flag are visible. rx_buf_valid rises one edge after the receive enable is visible, because the enable must first move the receive control into RX_LIVE. The bench waits for tx_req before pulsing tx_done, and it allows two edges after an enable before it checks the receive offer. irq follows the source and mask registers with no extra delay. The bench compares it against its own source and mask model 1 ns after every rising edge.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    localparam int HOST_AW = 12;

    localparam logic [HOST_AW-1:0] ADR_MODE = 12'h000;
    localparam logic [HOST_AW-1:0] ADR_ISRC = 12'h004;
    localparam logic [HOST_AW-1:0] ADR_IMSK = 12'h008;
    localparam logic [HOST_AW-1:0] ADR_TXN  = 12'h00C;
    localparam logic [HOST_AW-1:0] DESC_BASE = 12'h400;

    // status word flag positions
    localparam int B_RDY  = 15;
    localparam int B_IRQ  = 14;
    localparam int B_WRAP = 13;
    localparam int B_PAD  = 12;
    localparam int B_CRC  = 11;

    // interrupt source positions
    localparam int I_TXF  = 0;
    localparam int I_TXE  = 1;
    localparam int I_RXF  = 2;
    localparam int I_RXE  = 3;
    localparam int I_BUSY = 4;
    localparam int I_RXC  = 6;

    typedef enum logic {TX_IDLE, TX_XFER} tx_state_t;
    typedef enum logic {RX_OFF, RX_LIVE} rx_state_t;

    function automatic logic tx_has_err(input logic [8:0] s);
        return s[8] | s[3] | s[2] | s[0];
    endfunction
endpackage

// File: rtl/bdr_desc_table.sv
module bdr_desc_table #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [IDX_W-1:0]     host_idx,
    input  logic                 host_sel_ptr,
    input  logic [31:0]          host_wdata,
    input  logic                 tx_wb_we,
    input  logic [IDX_W-1:0]     tx_wb_idx,
    input  logic [31:0]          tx_wb_data,
    input  logic                 rx_wb_we,
    input  logic [IDX_W-1:0]     rx_wb_idx,
    input  logic [31:0]          rx_wb_data,
    output logic [N-1:0][31:0]   stat_o,
    output logic [N-1:0][31:0]   ptr_o
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_o[g] <= '0;
            end else if (rx_wb_we && rx_wb_idx == IDX_W'(g)) begin
                stat_o[g] <= rx_wb_data;
            end else if (tx_wb_we && tx_wb_idx == IDX_W'(g)) begin
                stat_o[g] <= tx_wb_data;
            end else if (host_we && !host_sel_ptr && host_idx == IDX_W'(g)) begin
                stat_o[g] <= host_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_o[g] <= '0;
            end else if (host_we && host_sel_ptr && host_idx == IDX_W'(g)) begin
                ptr_o[g] <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/bdr_tx_ring.sv
module bdr_tx_ring
    import bdr_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [N-1:0][31:0] stat_i,
    input  logic [N-1:0][31:0] ptr_i,
    input  logic               tx_done,
    input  logic [8:0]         tx_status,
    output logic               tx_req,
    output logic [15:0]        tx_len,
    output logic [31:0]        tx_ptr,
    output logic               tx_pad,
    output logic               tx_crc,
    output logic               wb_we,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [31:0]        wb_data,
    output logic               ev_frame,
    output logic               ev_err
);
    tx_state_t        state, state_nx;
    logic [IDX_W-1:0] idx, cur_idx;
    logic [31:0]      cur_stat, cur_ptr;
    logic             finish;

    assign finish = (state == TX_XFER) && tx_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (en && stat_i[idx][B_RDY]) state_nx = TX_XFER;
            TX_XFER: if (tx_done)                  state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            idx      <= '0;
            cur_idx  <= '0;
            cur_stat <= '0;
            cur_ptr  <= '0;
        end else begin
            state <= state_nx;
            if (state == TX_IDLE && state_nx == TX_XFER) begin
                cur_idx  <= idx;
                cur_stat <= stat_i[idx];
                cur_ptr  <= ptr_i[idx];
            end
            if (!en) begin
                idx <= '0;
            end else if (finish) begin
                if (cur_stat[B_WRAP] || cur_idx == IDX_W'(N-1)) idx <= '0;
                else                                            idx <= cur_idx + 1'b1;
            end
        end
    end

    always_comb begin
        tx_req   = (state == TX_XFER);
        tx_len   = cur_stat[31:16];
        tx_ptr   = cur_ptr;
        tx_pad   = cur_stat[B_PAD];
        tx_crc   = cur_stat[B_CRC];
        wb_we    = finish;
        wb_idx   = cur_idx;
        wb_data  = {cur_stat[31:16], 1'b0, cur_stat[14:9], tx_status};
        ev_err   = finish && cur_stat[B_IRQ] && tx_has_err(tx_status);
        ev_frame = finish && cur_stat[B_IRQ] && !tx_has_err(tx_status);
    end
endmodule

// File: rtl/bdr_rx_ring.sv
module bdr_rx_ring
    import bdr_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [N-1:0][31:0] stat_i,
    input  logic [N-1:0][31:0] ptr_i,
    input  logic               rx_done,
    input  logic [15:0]        rx_len,
    input  logic [8:0]         rx_status,
    output logic               rx_buf_valid,
    output logic [31:0]        rx_ptr,
    output logic               wb_we,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [31:0]        wb_data,
    output logic               ev_frame,
    output logic               ev_err,
    output logic               ev_ctrl,
    output logic               ev_busy,
    output logic               live
);
    rx_state_t        state, state_nx;
    logic [IDX_W-1:0] idx, base;
    logic             has_ring, irq_req, bad;

    assign has_ring = tx_count < CNT_W'(N);
    assign base     = has_ring ? IDX_W'(tx_count) : '0;

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_OFF:  if (en)  state_nx = RX_LIVE;
            RX_LIVE: if (!en) state_nx = RX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_OFF;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == RX_OFF || !en) begin
                idx <= base;
            end else if (wb_we) begin
                if (stat_i[idx][B_WRAP] || idx == IDX_W'(N-1)) idx <= base;
                else                                           idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        live         = (state == RX_LIVE);
        rx_buf_valid = live && has_ring && stat_i[idx][B_RDY];
        rx_ptr       = ptr_i[idx];
        wb_we        = rx_done && rx_buf_valid;
        wb_idx       = idx;
        wb_data      = {rx_len, 1'b0, stat_i[idx][14:9], rx_status};
        irq_req      = stat_i[idx][B_IRQ];
        bad          = |rx_status[7:0];
        ev_err       = wb_we && irq_req && bad;
        ev_ctrl      = wb_we && irq_req && !bad && rx_status[8];
        ev_frame     = wb_we && irq_req && !bad && !rx_status[8];
        ev_busy      = rx_done && live && !rx_buf_valid;
    end
endmodule

// File: rtl/bdr_irq.sv
module bdr_irq #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_clr_we,
    input  logic            mask_we,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] set_vec,
    output logic [NSRC-1:0] src_q,
    output logic [NSRC-1:0] mask_q,
    output logic            irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q <= (src_q & ~(src_clr_we ? wdata : '0)) | set_vec;
            if (mask_we) mask_q <= wdata;
        end
    end

    assign irq = |(src_q & mask_q);
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
    import bdr_pkg::*;
#(
    parameter int NUM_DESC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               tx_req,
    output logic [15:0]        tx_len,
    output logic [31:0]        tx_ptr,
    output logic               tx_pad,
    output logic               tx_crc,
    input  logic               tx_done,
    input  logic [8:0]         tx_status,
    output logic               rx_buf_valid,
    output logic [31:0]        rx_ptr,
    input  logic               rx_done,
    input  logic [15:0]        rx_len,
    input  logic [8:0]         rx_status,
    output logic               irq
);
    localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
    localparam int CNT_W = $clog2(NUM_DESC + 1);
    localparam int NSRC  = 7;
    localparam logic [HOST_AW-4:0] SLOTS = (HOST_AW-3)'(NUM_DESC);

    logic [1:0]                 mode_q;
    logic [CNT_W-1:0]           txn_q;
    logic [NUM_DESC-1:0][31:0]  stat, ptr;
    logic [HOST_AW-1:0]         desc_off;
    logic                       desc_hit;
    logic [IDX_W-1:0]           desc_idx;
    logic                       tx_wb_we, rx_wb_we;
    logic [IDX_W-1:0]           tx_wb_idx, rx_wb_idx;
    logic [31:0]                tx_wb_data, rx_wb_data;
    logic                       tx_ev_f, tx_ev_e, rx_ev_f, rx_ev_e, rx_ev_c, rx_ev_b;
    logic                       rx_live;
    logic [NSRC-1:0]            int_src, int_mask, set_vec;

    assign desc_off = host_addr - DESC_BASE;
    assign desc_hit = (host_addr >= DESC_BASE) && (desc_off[HOST_AW-1:3] < SLOTS);
    assign desc_idx = desc_off[IDX_W+2:3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            txn_q  <= CNT_W'(NUM_DESC / 2);
        end else if (host_we) begin
            if (host_addr == ADR_MODE) mode_q <= host_wdata[1:0];
            if (host_addr == ADR_TXN)
                txn_q <= (host_wdata > 32'(NUM_DESC)) ? CNT_W'(NUM_DESC)
                                                      : host_wdata[CNT_W-1:0];
        end
    end

    bdr_desc_table #(.N(NUM_DESC), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we && desc_hit), .host_idx(desc_idx),
        .host_sel_ptr(desc_off[2]), .host_wdata(host_wdata),
        .tx_wb_we(tx_wb_we), .tx_wb_idx(tx_wb_idx), .tx_wb_data(tx_wb_data),
        .rx_wb_we(rx_wb_we), .rx_wb_idx(rx_wb_idx), .rx_wb_data(rx_wb_data),
        .stat_o(stat), .ptr_o(ptr)
    );

    bdr_tx_ring #(.N(NUM_DESC), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(mode_q[1]),
        .stat_i(stat), .ptr_i(ptr),
        .tx_done(tx_done), .tx_status(tx_status),
        .tx_req(tx_req), .tx_len(tx_len), .tx_ptr(tx_ptr),
        .tx_pad(tx_pad), .tx_crc(tx_crc),
        .wb_we(tx_wb_we), .wb_idx(tx_wb_idx), .wb_data(tx_wb_data),
        .ev_frame(tx_ev_f), .ev_err(tx_ev_e)
    );

    bdr_rx_ring #(.N(NUM_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(mode_q[0]), .tx_count(txn_q),
        .stat_i(stat), .ptr_i(ptr),
        .rx_done(rx_done), .rx_len(rx_len), .rx_status(rx_status),
        .rx_buf_valid(rx_buf_valid), .rx_ptr(rx_ptr),
        .wb_we(rx_wb_we), .wb_idx(rx_wb_idx), .wb_data(rx_wb_data),
        .ev_frame(rx_ev_f), .ev_err(rx_ev_e), .ev_ctrl(rx_ev_c),
        .ev_busy(rx_ev_b), .live(rx_live)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[I_TXF]  = tx_ev_f;
        set_vec[I_TXE]  = tx_ev_e;
        set_vec[I_RXF]  = rx_ev_f;
        set_vec[I_RXE]  = rx_ev_e;
        set_vec[I_BUSY] = rx_ev_b;
        set_vec[I_RXC]  = rx_ev_c;
    end

    bdr_irq #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .src_clr_we(host_we && host_addr == ADR_ISRC),
        .mask_we(host_we && host_addr == ADR_IMSK),
        .wdata(host_wdata[NSRC-1:0]), .set_vec(set_vec),
        .src_q(int_src), .mask_q(int_mask), .irq(irq)
    );

    always_comb begin
        host_rdata = '0;
        if (desc_hit) begin
            host_rdata = desc_off[2] ? ptr[desc_idx] : stat[desc_idx];
        end else begin
            case (host_addr)
                ADR_MODE: host_rdata = {30'd0, mode_q};
                ADR_ISRC: host_rdata = {{(32-NSRC){1'b0}}, int_src};
                ADR_IMSK: host_rdata = {{(32-NSRC){1'b0}}, int_mask};
                ADR_TXN:  host_rdata = 32'(txn_q);
                default:  host_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_req,
    input logic        tx_done,
    input logic [31:0] tx_ptr,
    input logic        rx_done,
    input logic        rx_buf_valid,
    input logic        rx_live,
    input logic [1:0]  mode_q,
    input logic [6:0]  int_src,
    input logic [6:0]  int_mask,
    input logic        irq
);
    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> tx_req);

    // R3
    tx_ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> $stable(tx_ptr));

    // R4
    tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_done) |=> !tx_req);

    // R8
    tx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[1] && !tx_req) |=> !tx_req);

    // R11
    rx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_live && !rx_buf_valid) |=> int_src[4]);

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 7'd0) |-> !irq);
endmodule

bind bd_ring_engine bdr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done),
    .tx_ptr(tx_ptr), .rx_done(rx_done), .rx_buf_valid(rx_buf_valid),
    .rx_live(rx_live), .mode_q(mode_q), .int_src(int_src),
    .int_mask(int_mask), .irq(irq)
);

// File: tb/tb_bd_ring_engine.sv
`timescale 1ns/1ps
module tb_bd_ring_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_req, tx_pad, tx_crc;
    logic [15:0] tx_len;
    logic [31:0] tx_ptr;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_status = '0;
    logic        rx_buf_valid;
    logic [31:0] rx_ptr;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_status = '0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    logic [6:0] m_src = '0;
    logic [6:0] m_mask = '0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    bd_ring_engine #(.NUM_DESC(16)) dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_req(tx_req), .tx_len(tx_len), .tx_ptr(tx_ptr), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
        .rx_buf_valid(rx_buf_valid), .rx_ptr(rx_ptr), .rx_done(rx_done),
        .rx_len(rx_len), .rx_status(rx_status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of the interrupt line against the model (R12)
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            compared++;
            if (irq !== |(m_src & m_mask)) begin
                mismatched++;
                $display("FAIL R12 irq line: actual %0b expected %0b", irq, |(m_src & m_mask));
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        if (a == 12'h004) m_src = m_src & ~d[6:0];
        if (a == 12'h008) m_mask = d[6:0];
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_tx;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            if (tx_req) break;
            @(negedge clk);
        end
    endtask

    task automatic tx_finish(input logic [8:0] st, input logic [6:0] ev);
        tx_done = 1'b1; tx_status = st;
        m_src = m_src | ev;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic rx_push(input logic [15:0] len, input logic [8:0] st, input logic [6:0] ev);
        @(negedge clk);
        rx_done = 1'b1; rx_len = len; rx_status = st;
        m_src = m_src | ev;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, rv); chk("R1 mode", rv, 32'h0);
        rd(12'h004, rv); chk("R1 source", rv, 32'h0);
        rd(12'h008, rv); chk("R1 mask", rv, 32'h0);
        rd(12'h00C, rv); chk("R1 tx count", rv, 32'd8);
        chk("R1 tx_req", 32'(tx_req), 32'h0);
        chk("R1 rx_buf_valid", 32'(rx_buf_valid), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 clamp
        wr(12'h00C, 32'd100);
        rd(12'h00C, rv); chk("R2 clamp", rv, 32'd16);
        wr(12'h00C, 32'd4);
        rd(12'h00C, rv); chk("R2 store", rv, 32'd4);

        wr(12'h008, 32'h7F);
        wr(12'h400, 32'h003CD000); wr(12'h404, 32'h1000);
        wr(12'h408, 32'h00C8E800); wr(12'h40C, 32'h2000);
        wr(12'h000, 32'h2);

        // R3 fetch of entry 0
        wait_tx;
        chk("R3 tx_req", 32'(tx_req), 32'h1);
        chk("R3 tx_len", 32'(tx_len), 32'd60);
        chk("R3 tx_ptr", tx_ptr, 32'h1000);
        chk("R3 tx_pad", 32'(tx_pad), 32'h1);
        chk("R3 tx_crc", 32'(tx_crc), 32'h0);
        tx_finish(9'h000, 7'h01);
        rd(12'h400, rv); chk("R4 writeback entry 0", rv, 32'h003C5000);
        rd(12'h004, rv); chk("R6 tx frame bit", rv, 32'h01);
        wr(12'h004, 32'h01);
        rd(12'h004, rv); chk("R7 clear", rv, 32'h00);

        // R5 advance to entry 1
        wait_tx;
        chk("R5 next len", 32'(tx_len), 32'd200);
        chk("R5 next ptr", tx_ptr, 32'h2000);
        chk("R3 tx_crc", 32'(tx_crc), 32'h1);
        tx_finish(9'h008, 7'h02);
        rd(12'h408, rv); chk("R4 writeback entry 1", rv, 32'h00C86808);
        rd(12'h004, rv); chk("R6 tx error bit", rv, 32'h02);
        wr(12'h004, 32'h7F);
        repeat (5) @(negedge clk);
        chk("R5 stall not ready", 32'(tx_req), 32'h0);

        // R5 wrap back to entry 0, R6 no irq request
        wr(12'h400, 32'h003C9000);
        wait_tx;
        chk("R5 wrap ptr", tx_ptr, 32'h1000);
        tx_finish(9'h010, 7'h00);
        rd(12'h400, rv); chk("R4 writeback retry", rv, 32'h003C1010);
        rd(12'h004, rv); chk("R6 no irq request", rv, 32'h00);

        // R8 disable resets the transmit pointer (it sat at entry 1)
        wr(12'h000, 32'h0);
        wr(12'h400, 32'h00508000);
        wr(12'h408, 32'h005AA000);
        wr(12'h000, 32'h2);
        wait_tx;
        chk("R8 tx restart ptr", tx_ptr, 32'h1000);
        chk("R8 tx restart len", 32'(tx_len), 32'd80);
        tx_finish(9'h000, 7'h00);
        wait_tx;
        chk("R5 then entry 1", 32'(tx_len), 32'd90);
        tx_finish(9'h000, 7'h00);

        // receive ring at entries 4 and 5
        wr(12'h420, 32'h0000C000); wr(12'h424, 32'h8000);
        wr(12'h428, 32'h0000E000); wr(12'h42C, 32'h9000);
        wr(12'h000, 32'h3);
        repeat (2) @(negedge clk);
        chk("R9 offer valid", 32'(rx_buf_valid), 32'h1);
        chk("R9 offer ptr", rx_ptr, 32'h8000);
        rx_push(16'd64, 9'h000, 7'h04);
        rd(12'h420, rv); chk("R10 writeback entry 4", rv, 32'h00404000);
        chk("R5 rx advance", rx_ptr, 32'h9000);
        rd(12'h004, rv); chk("R6 rx frame bit", rv, 32'h04);
        rx_push(16'd70, 9'h002, 7'h08);
        rd(12'h428, rv); chk("R10 writeback entry 5", rv, 32'h00466002);
        rd(12'h004, rv); chk("R6 rx error bit", rv, 32'h0C);
        chk("R9 no empty buffer", 32'(rx_buf_valid), 32'h0);
        chk("R5 rx wrap", rx_ptr, 32'h8000);

        // R11 busy drop
        rx_push(16'd99, 9'h000, 7'h10);
        rd(12'h420, rv); chk("R11 descriptor kept", rv, 32'h00404000);
        rd(12'h004, rv); chk("R11 busy bit", rv, 32'h1C);
        chk("R11 pointer kept", rx_ptr, 32'h8000);

        // control frame completion
        wr(12'h420, 32'h0000C000);
        rx_push(16'd60, 9'h100, 7'h40);
        rd(12'h420, rv); chk("R10 control frame", rv, 32'h003C4100);
        rd(12'h004, rv); chk("R6 rx control bit", rv, 32'h5C);

        // R12 masking
        wr(12'h008, 32'h00);
        @(negedge clk); chk("R12 all masked", 32'(irq), 32'h0);
        wr(12'h008, 32'h40);
        @(negedge clk); chk("R12 control unmasked", 32'(irq), 32'h1);
        wr(12'h008, 32'h01);
        @(negedge clk); chk("R12 idle bit unmasked", 32'(irq), 32'h0);

        // R8 receive pointer reset (was at entry 5)
        chk("R8 rx before", rx_ptr, 32'h9000);
        wr(12'h000, 32'h2);
        wr(12'h000, 32'h3);
        repeat (2) @(negedge clk);
        chk("R8 rx restart", rx_ptr, 32'h8000);

        // R13 addressing
        wr(12'h47C, 32'hABCD0000);
        rd(12'h47C, rv); chk("R13 last pointer", rv, 32'hABCD0000);
        rd(12'h404, rv); chk("R13 entry 0 pointer", rv, 32'h1000);
        rd(12'h40C, rv); chk("R13 entry 1 pointer", rv, 32'h2000);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule